// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Controller

This block collects level-sensitive interrupt requests from up to 32 sources into one raw vector. It drives two processor request lines from that vector. One is the normal request (IRQ) and the other is the fast request (FIQ). Each line has its own enable mask. A line is asserted while any raw bit that its mask enables is high. The controller does no priority encoding and no vectoring. Software reads the status words and works out for itself which source needs service.

Source 0 has no pin. It is a flop that software sets and clears through two registers, so the processor can raise an interrupt on itself. Each mask has a set port and a clear port. Software can therefore change single enable bits without a read-modify-write sequence.

Two instances can be cascaded. The IRQ line of a secondary instance feeds source line 26 of the primary instance. The register port is a plain synchronous strobe interface, and a read returns its data one cycle after the strobe.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, both enable masks are zero, the software bit is zero, and `irq_o` and `fiq_o` are low.
- R2: A write to index 2 ORs the write data into the IRQ mask. A write to index 10 ORs it into the FIQ mask. A read of index 2 returns the IRQ mask, and a read of index 10 returns the FIQ mask.
- R3: A write to index 3 clears every IRQ mask bit that is written as one. A write to index 11 does the same for the FIQ mask. Mask bits written as zero keep their value.
- R4: A read of index 1 or index 9 returns the raw vector. Bits 31..1 of the raw vector are `src_in[31:1]` and bit 0 is the software bit.
- R5: A read of index 0 returns the raw vector ANDed with the IRQ mask. A read of index 8 returns the raw vector ANDed with the FIQ mask.
- R6: A write to index 4 with data bit 0 set sets the software bit. A write to index 5 with data bit 0 set clears it. Data bits 31..1 have no effect on either write. A read of index 4 returns the software bit in bit 0, with all other bits zero.
- R7: `irq_o` is registered. At each clock edge it takes the value of (raw AND IRQ mask) != 0, so it follows a change on the sources or the mask one edge later.
- R8: `fiq_o` is registered in the same way from (raw AND FIQ mask) != 0. It does not depend on the IRQ mask.
- R9: A read of any index other than 0, 1, 2, 4, 8, 9 or 10 returns zero. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`.
- R10: A write to any index other than 2, 3, 4, 5, 10 or 11 changes no mask and does not change the software bit.
- R11: The pin `src_in[0]` has no effect on the raw vector, the status reads or either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, sampled at the clock edge |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Level interrupt sources. Bit 0 is not used. |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench runs several kinds of check:
- **Mask updates.** It sets mask bits across several writes and then clears only part of them. A design that loads the mask instead of ORing into it, or that clears bits written as zero, shows the wrong value on the next mask read.
- **Software bit.** It writes the software set and clear registers with data bit 0 low and all other bits high. It also drives `src_in[0]` high. A design that decodes the wrong data bit, or lets the pin reach the raw vector, shows a wrong raw word or a spurious `irq_o`.
- **Output latency and independence.** It samples each output just before and just after the edge that follows a source change, so a missing or doubled output register is caught. With only one mask enabled, the other output must stay low.
- **Unmapped and read-only indices.** It reads the unmapped and write-only indices, which must return zero. It writes the read-only and unmapped indices and then reads the masks back. A wrong decode shows up as corrupted state.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    RI_IRQ_STAT = 4'd0,
    RI_IRQ_RAW  = 4'd1,
    RI_IRQ_ENS  = 4'd2,
    RI_IRQ_ENC  = 4'd3,
    RI_SW_SET   = 4'd4,
    RI_SW_CLR   = 4'd5,
    RI_FIQ_STAT = 4'd8,
    RI_FIQ_RAW  = 4'd9,
    RI_FIQ_ENS  = 4'd10,
    RI_FIQ_ENC  = 4'd11
  } reg_idx_e;

  localparam int LANE_IRQ = 0;
  localparam int LANE_FIQ = 1;
  localparam int NUM_LANES = 2;

  function automatic logic idx_readable(input logic [IDX_W-1:0] a);
    case (a)
      RI_IRQ_STAT, RI_IRQ_RAW, RI_IRQ_ENS, RI_SW_SET,
      RI_FIQ_STAT, RI_FIQ_RAW, RI_FIQ_ENS: idx_readable = 1'b1;
      default:                             idx_readable = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/icc_mask.sv
module icc_mask #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (set_stb) mask <= mask | wdata;
    else if (clr_stb) mask <= mask & ~wdata;
  end

  p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask & $past(wdata)) == $past(wdata)));
  p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask & $past(mask)) == $past(mask)));
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> ((mask & $past(wdata)) == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask));
endmodule

// File: rtl/icc_soft.sv
module icc_soft (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic wbit,
  output logic soft_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                soft_q <= 1'b0;
    else if (set_stb && wbit)  soft_q <= 1'b1;
    else if (clr_stb && wbit)  soft_q <= 1'b0;
  end

  p_soft_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && wbit) |=> soft_q);
  p_soft_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && wbit && !set_stb) |=> !soft_q);
  p_soft_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !((set_stb || clr_stb) && wbit) |=> $stable(soft_q));
endmodule

// File: rtl/icc_rdmux.sv
module icc_rdmux
  import icc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] addr,
  input  logic [W-1:0]     raw,
  input  logic [W-1:0]     irq_mask,
  input  logic [W-1:0]     fiq_mask,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] sel;

  always_comb begin
    case (reg_idx_e'(addr))
      RI_IRQ_STAT:            sel = raw & irq_mask;
      RI_IRQ_RAW, RI_FIQ_RAW: sel = raw;
      RI_IRQ_ENS:             sel = irq_mask;
      RI_SW_SET:              sel = {{(W-1){1'b0}}, raw[0]};
      RI_FIQ_STAT:            sel = raw & fiq_mask;
      RI_FIQ_ENS:             sel = fiq_mask;
      default:                sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= sel;
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !idx_readable(addr)) |=> (rdata == '0));
  p_masked_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (addr == RI_IRQ_STAT)) |=> ((rdata & ~$past(irq_mask)) == '0));
endmodule

// File: rtl/icc_out.sv
module icc_out
  import icc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] pend,
  output logic [NUM_LANES-1:0] req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= pend;
  end

  p_irq_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend[LANE_IRQ] |=> req_q[LANE_IRQ]);
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[LANE_IRQ] |=> !req_q[LANE_IRQ]);
  p_fiq_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend[LANE_FIQ] |=> req_q[LANE_FIQ]);
  p_fiq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[LANE_FIQ] |=> !req_q[LANE_FIQ]);
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [IDX_W-1:0]   bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam logic [IDX_W-1:0] ENS_IDX [NUM_LANES] = '{RI_IRQ_ENS, RI_FIQ_ENS};
  localparam logic [IDX_W-1:0] ENC_IDX [NUM_LANES] = '{RI_IRQ_ENC, RI_FIQ_ENC};

  logic [NUM_SRC-1:0]   raw;
  logic                 soft_q;
  logic [NUM_SRC-1:0]   lane_mask [NUM_LANES];
  logic [NUM_LANES-1:0] lane_pend;
  logic [NUM_LANES-1:0] lane_req;

  // Bit 0 comes from the software flop, the pin is not used.
  assign raw = {src_in[NUM_SRC-1:1], soft_q};

  icc_soft u_soft (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_stb(bus_wr && (bus_addr == RI_SW_SET)),
    .clr_stb(bus_wr && (bus_addr == RI_SW_CLR)),
    .wbit   (bus_wdata[0]),
    .soft_q (soft_q)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    icc_mask #(.W(NUM_SRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_stb(bus_wr && (bus_addr == ENS_IDX[l])),
      .clr_stb(bus_wr && (bus_addr == ENC_IDX[l])),
      .wdata  (bus_wdata),
      .mask   (lane_mask[l])
    );
    assign lane_pend[l] = |(raw & lane_mask[l]);
  end

  icc_rdmux #(.W(NUM_SRC)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (bus_rd),
    .addr    (bus_addr),
    .raw     (raw),
    .irq_mask(lane_mask[LANE_IRQ]),
    .fiq_mask(lane_mask[LANE_FIQ]),
    .rdata   (bus_rdata)
  );

  icc_out u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (lane_pend),
    .req_q(lane_req)
  );

  assign irq_o = lane_req[LANE_IRQ];
  assign fiq_o = lane_req[LANE_FIQ];

  p_pin0_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mask[LANE_IRQ] == 32'h1 && !soft_q) |=> !irq_o);
endmodule

// File: tb/tb_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fiq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t rq [$];

  always #4 clk = ~clk;

  irq_fiq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    rq.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares each read result one edge after the strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        rd_item_t it;
        #1;
        if (rq.size() == 0) begin
          chk("R9 unexpected read", 32'h1, 32'h0);
        end else begin
          it = rq.pop_front();
          chk(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq after reset", {31'b0, fiq_o}, 32'h0);
    rd(4'd2, 32'h0, "R1 irq mask reset");
    rd(4'd10, 32'h0, "R1 fiq mask reset");
    rd(4'd4, 32'h0, "R1 soft bit reset");

    src_in = 32'h0000_0F00;
    wr(4'd2, 32'h0000_0300);
    rd(4'd2, 32'h0000_0300, "R2 irq mask set");
    wr(4'd2, 32'h0001_0000);
    rd(4'd2, 32'h0001_0300, "R2 irq mask OR");
    rd(4'd1, 32'h0000_0F00, "R4 raw via 1");
    rd(4'd0, 32'h0000_0300, "R5 irq masked");
    chk("R7 irq high", {31'b0, irq_o}, 32'h1);
    chk("R8 fiq stays low", {31'b0, fiq_o}, 32'h0);

    // R7 latency: change source mid-cycle, look before and after the edge.
    @(negedge clk);
    src_in = 32'h0;
    #1;
    chk("R7 irq before edge", {31'b0, irq_o}, 32'h1);
    @(posedge clk); #1;
    chk("R7 irq after edge", {31'b0, irq_o}, 32'h0);

    wr(4'd10, 32'h0000_0004);
    rd(4'd10, 32'h0000_0004, "R2 fiq mask set");
    @(negedge clk);
    src_in = 32'h0000_0004;
    #1;
    chk("R8 fiq before edge", {31'b0, fiq_o}, 32'h0);
    @(posedge clk); #1;
    chk("R8 fiq after edge", {31'b0, fiq_o}, 32'h1);
    chk("R8 irq independent", {31'b0, irq_o}, 32'h0);
    rd(4'd8, 32'h0000_0004, "R5 fiq masked");
    rd(4'd9, 32'h0000_0004, "R4 raw via 9");

    wr(4'd3, 32'h0000_0100);
    rd(4'd2, 32'h0001_0200, "R3 irq mask partial clear");
    wr(4'd11, 32'hFFFF_FFFF);
    rd(4'd10, 32'h0, "R3 fiq mask clear");
    chk("R3 fiq low after clear", {31'b0, fiq_o}, 32'h0);

    src_in = 32'h0;
    wr(4'd4, 32'hFFFF_FFFE);
    rd(4'd4, 32'h0, "R6 soft set needs bit0");
    wr(4'd4, 32'h0000_0001);
    rd(4'd4, 32'h1, "R6 soft set");
    rd(4'd1, 32'h1, "R6 raw bit0 from soft");
    wr(4'd2, 32'h0000_0001);
    idle(1);
    chk("R6 irq from soft", {31'b0, irq_o}, 32'h1);
    wr(4'd5, 32'hFFFF_FFFE);
    rd(4'd4, 32'h1, "R6 soft clear needs bit0");
    wr(4'd5, 32'h0000_0001);
    rd(4'd4, 32'h0, "R6 soft clear");
    chk("R6 irq low after soft clear", {31'b0, irq_o}, 32'h0);

    src_in = 32'h0000_0001;
    idle(2);
    chk("R11 pin0 no irq", {31'b0, irq_o}, 32'h0);
    rd(4'd1, 32'h0, "R11 pin0 not in raw");
    rd(4'd0, 32'h0, "R11 pin0 not in status");
    src_in = 32'h0;

    rd(4'd3, 32'h0, "R9 read idx3");
    rd(4'd5, 32'h0, "R9 read idx5");
    rd(4'd11, 32'h0, "R9 read idx11");
    rd(4'd6, 32'h0, "R9 read idx6");
    rd(4'd7, 32'h0, "R9 read idx7");
    rd(4'd15, 32'h0, "R9 read idx15");

    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd12, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd2, 32'h0001_0201, "R10 irq mask untouched");
    rd(4'd10, 32'h0, "R10 fiq mask untouched");
    rd(4'd4, 32'h0, "R10 soft bit untouched");
    idle(2);
    chk("R10 irq still low", {31'b0, irq_o}, 32'h0);
    chk("R10 fiq still low", {31'b0, fiq_o}, 32'h0);

    idle(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule